// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

This block gathers 32 interrupt request lines into two processor interrupt outputs, a normal one and a critical one. Software sets each line up through a small word-addressed register port. A line is either edge-sensed or level-sensed, and it is either active-high (rising edge) or active-low (falling edge). A detected event is held in a pending-status register. Software clears a pending bit by writing a one to it. The pending bits are ANDed with an enable register to give a masked view. A critical-select register decides which masked bits feed the critical output and which feed the normal one.

Source numbering starts at the most significant bit. Source n sits in bit (31 - n) of every 32-bit register. The controller also reports the winning pending source, which is the highest-numbered source with an enabled pending bit. This is the source at the lowest-order set bit of the masked status. The index is available on dedicated output pins and through a vector register, which carries a valid flag in bit 31. A level-sensed line that is still active cannot be cleared: its pending bit sets again at once. For such a line, software must quiet the device before clearing the bit.

Top module: `irq_hub`

## Requirements
- R1: Source n (input pin src_i[n]) is reported in bit (31 - n) of the status, enable, critical-select, polarity and trigger registers. Register word addresses are: status 0, enable 2, critical-select 3, polarity 4, trigger 5, masked status 6, vector 7 and vector configuration 8. Unused addresses read as zero.
- R2: A trigger bit of 0 selects level sensing and 1 selects edge sensing. A polarity bit of 1 selects active-high or rising edge, and 0 selects active-low or falling edge. An edge is found by comparing the input with its registered previous value, after the polarity is applied.
- R3: Writing 1 to a status bit clears that bit, and writing 0 leaves it unchanged. Writing all ones clears every bit whose source has no new event.
- R4: A level-sensed source at its active level keeps its status bit set, even while a write-one-to-clear is applied to it.
- R5: An edge detected in the same cycle as a write-one-to-clear of that bit wins, and the bit stays set.
- R6: The masked status register (address 6) reads as status AND enable.
- R7: win_idx_o is the index of the highest-numbered source whose masked status bit is set. win_vld_o is 1 only when the masked status is nonzero. The vector register (address 7) reads the index in bits 4:0 and the valid flag in bit 31, with all other bits zero.
- R8: After reset, enable, critical-select, trigger, status and vector configuration are zero, polarity is all ones, and both interrupt outputs are low.
- R9: A status bit latches an event whether or not its source is enabled.
- R10: irq_crit_o is the registered OR of the masked status bits whose critical-select bit is 1. irq_norm_o is the registered OR of those whose critical-select bit is 0. Each follows the state of the previous cycle.
- R11: The vector configuration register (address 8) stores and reads back any 32-bit value.
- R12: Writes to the masked status and vector addresses have no effect. Read data appears in reg_rdata on the clock edge that samples reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt request lines, bit n is source n |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |
| win_idx_o | output | 5 | Index of the winning pending source |
| win_vld_o | output | 1 | A winning source exists |

## Verification
A wrong pending bit reaches the interrupt outputs one cycle after the status register takes it. It reaches the winner pins in the same cycle. The bench therefore compares both interrupt outputs and the winner pins against its own model on every cycle, so a corrupted status, enable or critical-select bit shows up within two cycles of the fault. Faults in the edge detector, and in the priority between a set and a clear, only show in the cycle where an event meets a clear. Directed sequences build those exact collisions and then read the status register back.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int unsigned ADR_STAT = 0;
  localparam int unsigned ADR_EN   = 2;
  localparam int unsigned ADR_CRIT = 3;
  localparam int unsigned ADR_POL  = 4;
  localparam int unsigned ADR_TRIG = 5;
  localparam int unsigned ADR_MSK  = 6;
  localparam int unsigned ADR_VEC  = 7;
  localparam int unsigned ADR_VCFG = 8;

  // event on one line: level sensing follows the active level,
  // edge sensing needs active now and inactive one cycle ago
  function automatic logic detect_set(logic act_now, logic act_prev, logic edge_mode);
    return edge_mode ? (act_now & ~act_prev) : act_now;
  endfunction

  // raw level to active level under a polarity bit
  function automatic logic apply_pol(logic raw, logic pol);
    return ~(raw ^ pol);
  endfunction

endpackage

// File: rtl/irq_sense.sv
module irq_sense
  import irq_hub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,    // register bit order
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] set_o,
  output logic [W-1:0] lvl_set_o
);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic prev_q;
    logic stat_q;
    logic act_now;
    logic act_prev;
    logic ev;

    assign act_now  = apply_pol(raw_i[g], pol_i[g]);
    assign act_prev = apply_pol(prev_q, pol_i[g]);
    assign ev       = detect_set(act_now, act_prev, trig_i[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        stat_q <= 1'b0;
      end else begin
        prev_q <= raw_i[g];
        stat_q <= (stat_q & ~clr_i[g]) | ev;
      end
    end

    assign status_o[g]  = stat_q;
    assign set_o[g]     = ev;
    assign lvl_set_o[g] = act_now & ~trig_i[g];
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter  int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  masked_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);

  // lowest set register bit, reported as a source number (W-1-bit)
  function automatic logic [IW-1:0] lowest_source(logic [W-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int b = W - 1; b >= 0; b--) begin
      if (m[b]) r = IW'(W - 1 - b);
    end
    return r;
  endfunction

  assign idx_o = lowest_source(masked_i);
  assign vld_o = |masked_i;

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter  int W  = 32,
  parameter  int AW = 4,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  src_i,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  input  logic          reg_wr,
  input  logic          reg_rd,
  output logic [W-1:0]  reg_rdata,
  output logic          irq_norm_o,
  output logic          irq_crit_o,
  output logic [IW-1:0] win_idx_o,
  output logic          win_vld_o
);

  logic [W-1:0] enable_q, crit_q, pol_q, trig_q, vcfg_q;
  logic [W-1:0] raw_r, status_q, set_mask, lvl_set, clr_mask, masked;
  logic [W-1:0] rd_mux;

  function automatic logic at(logic [AW-1:0] a, int unsigned code);
    return a == AW'(code);
  endfunction

  // source n -> register bit W-1-n
  always_comb begin
    for (int n = 0; n < W; n++) raw_r[W-1-n] = src_i[n];
  end

  assign clr_mask = (reg_wr && at(reg_addr, ADR_STAT)) ? reg_wdata : '0;

  irq_sense #(.W(W)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_i     (raw_r),
    .pol_i     (pol_q),
    .trig_i    (trig_q),
    .clr_i     (clr_mask),
    .status_o  (status_q),
    .set_o     (set_mask),
    .lvl_set_o (lvl_set)
  );

  assign masked = status_q & enable_q;

  irq_pick #(.W(W)) u_pick (
    .masked_i (masked),
    .idx_o    (win_idx_o),
    .vld_o    (win_vld_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      crit_q   <= '0;
      trig_q   <= '0;
      pol_q    <= '1;
      vcfg_q   <= '0;
    end else if (reg_wr) begin
      if (at(reg_addr, ADR_EN))   enable_q <= reg_wdata;
      if (at(reg_addr, ADR_CRIT)) crit_q   <= reg_wdata;
      if (at(reg_addr, ADR_POL))  pol_q    <= reg_wdata;
      if (at(reg_addr, ADR_TRIG)) trig_q   <= reg_wdata;
      if (at(reg_addr, ADR_VCFG)) vcfg_q   <= reg_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (at(reg_addr, ADR_STAT)) rd_mux = status_q;
    if (at(reg_addr, ADR_EN))   rd_mux = enable_q;
    if (at(reg_addr, ADR_CRIT)) rd_mux = crit_q;
    if (at(reg_addr, ADR_POL))  rd_mux = pol_q;
    if (at(reg_addr, ADR_TRIG)) rd_mux = trig_q;
    if (at(reg_addr, ADR_MSK))  rd_mux = masked;
    if (at(reg_addr, ADR_VCFG)) rd_mux = vcfg_q;
    if (at(reg_addr, ADR_VEC)) begin
      rd_mux[W-1]    = win_vld_o;
      rd_mux[IW-1:0] = win_idx_o;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      irq_norm_o <= 1'b0;
      irq_crit_o <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq_norm_o <= |(masked & ~crit_q);
      irq_crit_o <= |(masked & crit_q);
    end
  end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter  int W  = 32,
  localparam int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  status_q,
  input logic [W-1:0]  enable_q,
  input logic [W-1:0]  crit_q,
  input logic [W-1:0]  lvl_set,
  input logic [W-1:0]  set_mask,
  input logic [W-1:0]  clr_mask,
  input logic          irq_norm_o,
  input logic          irq_crit_o,
  input logic [IW-1:0] win_idx_o,
  input logic          win_vld_o
);

  logic [W-1:0] win_bit, below_win;
  assign win_bit   = W'(1) << (W - 1 - int'(win_idx_o));
  assign below_win = win_bit - W'(1);

  AST_LEVEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_set != '0) |=> ((status_q & $past(lvl_set)) == $past(lvl_set))); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((status_q & $past(clr_mask & ~set_mask)) == '0)); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((status_q & $past(set_mask)) == $past(set_mask))); // R5

  AST_NO_SPONTANEOUS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q & ~clr_mask) & ~status_q) == '0)); // R3

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> (((status_q & enable_q & win_bit) != '0) &&
                   ((status_q & enable_q & below_win) == '0))); // R7

  AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) == '0) |=> (!irq_norm_o && !irq_crit_o)); // R10

  AST_CRIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q & ~crit_q) == '0) |=> !irq_norm_o); // R10

endmodule

bind irq_hub irq_hub_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .status_q   (status_q),
  .enable_q   (enable_q),
  .crit_q     (crit_q),
  .lvl_set    (lvl_set),
  .set_mask   (set_mask),
  .clr_mask   (clr_mask),
  .irq_norm_o (irq_norm_o),
  .irq_crit_o (irq_crit_o),
  .win_idx_o  (win_idx_o),
  .win_vld_o  (win_vld_o)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        irq_n, irq_c, vld;
  logic [4:0]  idx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr(addr), .reg_wdata(wdata),
    .reg_wr(wr), .reg_rd(rd), .reg_rdata(rdata), .irq_norm_o(irq_n),
    .irq_crit_o(irq_c), .win_idx_o(idx), .win_vld_o(vld)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // ---------------- reference model (register bit order) ----------------
  logic [31:0] m_stat, m_en, m_crit, m_pol, m_trig, m_vcfg, m_prev, m_rdata;
  logic        m_irqn, m_irqc, m_rdv;

  function automatic logic [31:0] to_reg(logic [31:0] s);
    return {<<{s}};
  endfunction

  function automatic logic [5:0] model_win(logic [31:0] m); // {vld, idx}
    int b = 0;
    while (b < 32 && !m[b]) b++;
    if (b == 32) return 6'd0;
    return {1'b1, 5'(31 - b)};
  endfunction

  function automatic logic [31:0] model_read(logic [3:0] a);
    logic [5:0] w = model_win(m_stat & m_en);
    case (a)
      4'd0: return m_stat;
      4'd2: return m_en;
      4'd3: return m_crit;
      4'd4: return m_pol;
      4'd5: return m_trig;
      4'd6: return m_stat & m_en;
      4'd7: return {w[5], 26'd0, w[4:0]};
      4'd8: return m_vcfg;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat <= 0; m_en <= 0; m_crit <= 0; m_pol <= '1; m_trig <= 0;
      m_vcfg <= 0; m_prev <= 0; m_rdata <= 0; m_irqn <= 0; m_irqc <= 0; m_rdv <= 0;
    end else begin
      logic [31:0] now_a, old_a, ev, clr;
      now_a = ~(to_reg(src) ^ m_pol);
      old_a = ~(m_prev ^ m_pol);
      ev    = (now_a & ~m_trig) | (now_a & ~old_a & m_trig);
      clr   = (wr && addr == 4'd0) ? wdata : 32'd0;
      m_stat <= (m_stat & ~clr) | ev;
      m_prev <= to_reg(src);
      m_irqn <= |(m_stat & m_en & ~m_crit);
      m_irqc <= |(m_stat & m_en & m_crit);
      m_rdv  <= rd;
      if (rd) m_rdata <= model_read(addr);
      if (wr) begin
        case (addr)
          4'd2: m_en <= wdata;
          4'd3: m_crit <= wdata;
          4'd4: m_pol <= wdata;
          4'd5: m_trig <= wdata;
          4'd8: m_vcfg <= wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [5:0] w;
      w = model_win(m_stat & m_en);
      chk("R10 normal", {31'd0, irq_n}, {31'd0, m_irqn});
      chk("R10 critical", {31'd0, irq_c}, {31'd0, m_irqc});
      chk("R7 valid", {31'd0, vld}, {31'd0, w[5]});
      if (w[5]) chk("R7 index", {27'd0, idx}, {27'd0, w[4:0]});
      if (m_rdv) chk("R12 read data", rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  logic [31:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    rd_reg(4'd2, v); chk("R8 enable", v, 32'd0);
    rd_reg(4'd3, v); chk("R8 critical-select", v, 32'd0);
    rd_reg(4'd5, v); chk("R8 trigger", v, 32'd0);
    rd_reg(4'd4, v); chk("R8 polarity", v, 32'hFFFF_FFFF);
    rd_reg(4'd0, v); chk("R8 status", v, 32'd0);
    chk("R8 outputs", {30'd0, irq_n, irq_c}, 32'd0);

    // R9 disabled source latches, R1 bit mapping
    src[5] = 1'b1; @(negedge clk); src[5] = 1'b0; @(negedge clk);
    rd_reg(4'd0, v); chk("R9 R1 status bit 26", v, 32'h0400_0000);
    chk("R9 no irq while disabled", {31'd0, irq_n}, 32'd0);
    rd_reg(4'd6, v); chk("R6 masked empty", v, 32'd0);

    // R3 clear, then R4 level sticky
    wr_reg(4'd0, 32'h0400_0000);
    rd_reg(4'd0, v); chk("R3 cleared", v, 32'd0);
    wr_reg(4'd2, 32'hFFFF_FFFF);
    src[3] = 1'b1; src[20] = 1'b1; @(negedge clk);
    wr_reg(4'd0, 32'hFFFF_FFFF);
    rd_reg(4'd0, v); chk("R4 level resets", v, 32'h1000_0800);
    rd_reg(4'd7, v); chk("R7 vector highest-numbered", v, 32'h8000_0014);
    chk("R10 normal raised", {31'd0, irq_n}, 32'd1);
    wr_reg(4'd3, 32'h0000_0800);
    @(negedge clk);
    chk("R10 critical raised", {31'd0, irq_c}, 32'd1);
    src[3] = 1'b0; src[20] = 1'b0;
    @(negedge clk);
    wr_reg(4'd0, 32'hFFFF_FFFF);
    rd_reg(4'd0, v); chk("R3 all ones clears", v, 32'd0);
    rd_reg(4'd7, v); chk("R7 vector empty", v, 32'd0);

    // R2 falling edge on source 1, R5 rising edge vs clear on source 0
    src[1] = 1'b1; @(negedge clk);
    wr_reg(4'd5, 32'hC000_0000);
    wr_reg(4'd4, 32'hBFFF_FFFF);
    wr_reg(4'd0, 32'hFFFF_FFFF);
    rd_reg(4'd0, v); chk("R2 no event while high", v & 32'h4000_0000, 32'd0);
    src[1] = 1'b0; @(negedge clk); @(negedge clk);
    rd_reg(4'd0, v); chk("R2 falling edge", v & 32'h4000_0000, 32'h4000_0000);
    src[0] = 1'b1; @(negedge clk); src[0] = 1'b0; @(negedge clk);
    src[0] = 1'b1; wr_reg(4'd0, 32'h8000_0000);
    rd_reg(4'd0, v); chk("R5 edge beats clear", v & 32'h8000_0000, 32'h8000_0000);
    wr_reg(4'd0, 32'h8000_0000);
    rd_reg(4'd0, v); chk("R2 held input no new edge", v & 32'h8000_0000, 32'd0);
    src = '0;

    // R11 storage, R12 read-only addresses
    wr_reg(4'd8, 32'hA5C3_0F96);
    rd_reg(4'd8, v); chk("R11 vector config", v, 32'hA5C3_0F96);
    rd_reg(4'd6, v);
    wr_reg(4'd6, 32'hFFFF_FFFF);
    wr_reg(4'd7, 32'hFFFF_FFFF);
    rd_reg(4'd6, v); chk("R12 masked after write", v, 32'h4000_0000);
    rd_reg(4'd7, v); chk("R12 vector after write", v, 32'h8000_0001);

    // constrained random phase; the monitor checks every cycle
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [3:0] ra;
      if ($urandom % 4 == 0) src = $urandom;
      op = $urandom % 8;
      ra = 4'($urandom % 9);
      if (op == 0) begin
        addr = ra; wdata = $urandom;
        if (ra == 4'd4 && $urandom % 2 == 0) wdata = '1;
        wr = 1'b1;
      end else if (op < 4) begin
        addr = ra; rd = 1'b1;
      end
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule